// File: doc/BRIEF.md
# Serial Bit Sector Buffer

This block holds one sector's worth of single-bit data for a microcoded disk controller. A 12-bit buffer address register selects a location in a 1024 x 1 storage array. A write-mode flag decides whether the array is being filled. The bit offered for storage comes from one of two serial sources. A selection flag picks between separated disk read data and the serial line from the host-side interface.

The sequencer drives the block with decoded micro-operations, one per machine cycle, qualified by a cycle-enable input. The machine cycle is four clocks of the 20 MHz controller clock. The address operation increments the register or presets it to one of two values. The write-mode operation turns write mode on or off. Stores are lazy: there is no write strobe. The current input bit is stored at the old address only when the address changes while write mode is on, or when write mode is switched off. A single condition bit goes back to the sequencer. It carries the live input bit while writing and the stored bit at the current address while reading.

Top module: `serial_bit_buffer`

## Requirements
- R1: After reset the address register reads 0 and write mode is off, and reset stores nothing in the array.
- R2: An address operation (op code 2'b01) with arg[1] set increments the 12-bit address register, wrapping from 4095 to 0.
- R3: An address operation with arg[1] clear loads 0 when arg[0] is set and loads octal 6000 (3072) when arg[0] is clear.
- R4: A write-mode operation (op code 2'b10) sets write mode to arg[0]. Op codes 2'b00 and 2'b11 change nothing.
- R5: While write mode is on, an address operation that changes the register stores the current input bit at the old address before the register takes its new value.
- R6: An address operation whose result equals the current address stores nothing and leaves the register unchanged.
- R7: Switching write mode off while it is on first stores the current input bit at the current address. Switching it off while it is already off stores nothing.
- R8: The input bit is the disk read bit when the source-select input is 1, and the serial interface bit when it is 0.
- R9: The condition output equals the live input bit while write mode is on, and the stored bit at the current address while write mode is off.
- R10: With the cycle enable low, no operation takes effect: the address, write mode and array contents stay unchanged.
- R11: The array is indexed by the low 10 address bits, so addresses that differ by a multiple of 1024 share a location. Octal 6000, for example, reaches location 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle enable; operations take effect only when high |
| op | input | 2 | Decoded micro-operation: 01 address, 10 write mode, others none |
| arg | input | 2 | Operation argument bits |
| src_sel | input | 1 | Input source select: 1 disk read bit, 0 serial interface bit |
| disk_bit | input | 1 | Separated disk read data bit |
| serial_bit | input | 1 | Serial interface data bit |
| cond_out | output | 1 | Condition bit to the sequencer |
| addr_out | output | 12 | Current buffer address register |
| wmode_out | output | 1 | Current write-mode flag |

## Verification
The bound checker checks the following on every cycle:
- the increment and preset results of the address operations;
- the write-mode update;
- the hold of all state while the cycle enable is low;
- that the condition output follows the selected live source while writing.

Lazy storage can only be seen through later reads, so the bench's scenarios cover it. They cover the store on an address change, the store on leaving write mode, the absence of a store when write mode is already off, and aliasing of addresses above 1023. A reference model tracks the array contents and predicts the condition output after each operation.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ADDR  = 2'b01,
        OP_WMODE = 2'b10,
        OP_RSVD  = 2'b11
    } sbb_op_e;

    localparam int unsigned ARG_INC_BIT  = 1;
    localparam int unsigned ARG_ZERO_BIT = 0;
    localparam int unsigned ARG_ON_BIT   = 0;

endpackage

// File: rtl/sbb_addr_calc.sv
module sbb_addr_calc
    import sbb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] PRESET = ADDR_W'(12'o6000)
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [1:0]        arg,
    output logic [ADDR_W-1:0] addr_next,
    output logic              differs
);
    always_comb begin
        if (arg[ARG_INC_BIT]) begin
            addr_next = addr_q + ADDR_W'(1);
        end else if (arg[ARG_ZERO_BIT]) begin
            addr_next = '0;
        end else begin
            addr_next = PRESET;
        end
        differs = (addr_next != addr_q);
    end
endmodule

// File: rtl/sbb_bit_src.sv
module sbb_bit_src (
    input  logic src_sel,
    input  logic disk_bit,
    input  logic serial_bit,
    output logic in_bit
);
    always_comb begin
        in_bit = src_sel ? disk_bit : serial_bit;
    end
endmodule

// File: rtl/sbb_bit_array.sv
module sbb_bit_array #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);
    logic [DEPTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[widx] <= wbit;
        end
    end

    always_comb begin
        rbit = cells_q[ridx];
    end
endmodule

// File: rtl/serial_bit_buffer.sv
module serial_bit_buffer
    import sbb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 1024,
    parameter logic [ADDR_W-1:0] PRESET = ADDR_W'(12'o6000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic [1:0]        op,
    input  logic [1:0]        arg,
    input  logic              src_sel,
    input  logic              disk_bit,
    input  logic              serial_bit,
    output logic              cond_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              wmode_out
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wmode;
    } state_t;

    state_t st_q, st_d;

    logic              in_bit;
    logic [ADDR_W-1:0] addr_next;
    logic              addr_differs;
    logic              store_en;
    logic              stored_bit;
    sbb_op_e           op_e;

    sbb_bit_src u_src (
        .src_sel    (src_sel),
        .disk_bit   (disk_bit),
        .serial_bit (serial_bit),
        .in_bit     (in_bit)
    );

    sbb_addr_calc #(
        .ADDR_W (ADDR_W),
        .PRESET (PRESET)
    ) u_addr (
        .addr_q    (st_q.addr),
        .arg       (arg),
        .addr_next (addr_next),
        .differs   (addr_differs)
    );

    always_comb begin
        op_e     = sbb_op_e'(op);
        st_d     = st_q;
        store_en = 1'b0;
        if (cyc_en) begin
            unique case (op_e)
                OP_ADDR: begin
                    store_en  = st_q.wmode && addr_differs;
                    st_d.addr = addr_next;
                end
                OP_WMODE: begin
                    store_en   = st_q.wmode && !arg[ARG_ON_BIT];
                    st_d.wmode = arg[ARG_ON_BIT];
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    // Reset is asserted only through the state registers; store_en is
    // masked so no array write happens while reset is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sbb_bit_array #(
        .DEPTH (DEPTH)
    ) u_array (
        .clk  (clk),
        .we   (store_en && rst_n),
        .widx (st_q.addr[IDX_W-1:0]),
        .wbit (in_bit),
        .ridx (st_q.addr[IDX_W-1:0]),
        .rbit (stored_bit)
    );

    always_comb begin
        cond_out  = st_q.wmode ? in_bit : stored_bit;
        addr_out  = st_q.addr;
        wmode_out = st_q.wmode;
    end
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_en,
    input logic [1:0]        op,
    input logic [1:0]        arg,
    input logic              src_sel,
    input logic              disk_bit,
    input logic              serial_bit,
    input logic              cond_out,
    input logic [ADDR_W-1:0] addr_out,
    input logic              wmode_out
);
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == 2'b01 && arg[1]) |=> (addr_out == $past(addr_out) + ADDR_W'(1)));

    a_r3_preset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == 2'b01 && !arg[1] && arg[0]) |=> (addr_out == '0));

    a_r3_preset_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == 2'b01 && arg == 2'b00) |=> (addr_out == ADDR_W'(12'o6000)));

    a_r4_wmode_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == 2'b10) |=> (wmode_out == $past(arg[0])));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en) |=> ($stable(addr_out) && $stable(wmode_out)));

    a_r9_live_cond: assert property (@(posedge clk) disable iff (!rst_n)
        wmode_out |-> (cond_out == (src_sel ? disk_bit : serial_bit)));
endmodule

bind serial_bit_buffer sbb_checker #(.ADDR_W(ADDR_W)) i_sbb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_en     (cyc_en),
    .op         (op),
    .arg        (arg),
    .src_sel    (src_sel),
    .disk_bit   (disk_bit),
    .serial_bit (serial_bit),
    .cond_out   (cond_out),
    .addr_out   (addr_out),
    .wmode_out  (wmode_out)
);

// File: tb/test_serial_bit_buffer.sv
`timescale 1ns/1ps
module test_serial_bit_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [1:0]  arg = 2'b00;
    logic        src_sel = 1'b0;
    logic        disk_bit = 1'b0;
    logic        serial_bit = 1'b0;
    logic        cond_out;
    logic [11:0] addr_out;
    logic        wmode_out;

    always #5 clk = ~clk;

    serial_bit_buffer i_serial_bit_buffer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op(op), .arg(arg),
        .src_sel(src_sel), .disk_bit(disk_bit), .serial_bit(serial_bit),
        .cond_out(cond_out), .addr_out(addr_out), .wmode_out(wmode_out)
    );

    typedef struct {
        logic [11:0] addr;
        logic        wm;
        logic        cond;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;

    // reference model
    logic [11:0] m_addr = '0;
    logic        m_wm = 1'b0;
    logic        m_mem [1024];

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [1:0] o, input logic [1:0] a,
                        input logic sel, input logic dk, input logic sr, input string tag);
        logic        ib;
        logic [11:0] na;
        exp_t        e;
        @(negedge clk);
        cyc_en = en; op = o; arg = a; src_sel = sel; disk_bit = dk; serial_bit = sr;
        ib = sel ? dk : sr;
        if (en && o == 2'b01) begin
            na = a[1] ? m_addr + 12'd1 : (a[0] ? 12'd0 : 12'o6000);
            if (m_wm && na != m_addr) m_mem[m_addr[9:0]] = ib;
            m_addr = na;
        end else if (en && o == 2'b10) begin
            if (m_wm && !a[0]) m_mem[m_addr[9:0]] = ib;
            m_wm = a[0];
        end
        e.addr = m_addr;
        e.wm   = m_wm;
        e.cond = m_wm ? ib : m_mem[m_addr[9:0]];
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare after each active edge, before inputs change
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " addr"}, addr_out, e.addr);
            check({e.tag, " wmode"}, wmode_out, e.wm);
            check({e.tag, " cond"}, cond_out, e.cond);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset addr", addr_out, 0);
        check("R1 reset wmode", wmode_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // fill the first locations in write mode
        step(1, 2'b10, 2'b01, 0, 0, 1, "R4 wmode on / R9 live serial");
        step(1, 2'b01, 2'b10, 0, 0, 1, "R5 inc stores 1 at 0");
        step(1, 2'b01, 2'b10, 0, 1, 0, "R5 inc stores 0 at 1 R8 serial");
        step(1, 2'b01, 2'b10, 1, 1, 0, "R5 inc stores 1 at 2 R8 disk");
        step(1, 2'b00, 2'b11, 1, 0, 1, "R4 no-op op 00 R9 disk live");
        step(1, 2'b11, 2'b10, 0, 0, 1, "R4 no-op op 11");
        step(1, 2'b10, 2'b00, 1, 1, 0, "R7 wmode off stores 1 at 3");
        step(1, 2'b10, 2'b00, 0, 0, 0, "R7 off while off no store");
        // read back
        step(1, 2'b01, 2'b01, 0, 0, 0, "R3 preset zero R9 stored");
        step(1, 2'b01, 2'b10, 0, 0, 1, "R9 read 1");
        step(1, 2'b01, 2'b10, 1, 0, 0, "R9 read 2");
        step(1, 2'b01, 2'b10, 0, 0, 0, "R9 read 3 R7");
        // idle cycles
        step(0, 2'b01, 2'b10, 0, 0, 0, "R10 idle addr op");
        step(0, 2'b10, 2'b01, 0, 0, 1, "R10 idle wmode op");
        // equal-address preset in write mode
        step(1, 2'b01, 2'b01, 0, 0, 0, "R3 back to 0");
        step(1, 2'b10, 2'b01, 0, 0, 0, "R4 wmode on at 0");
        step(1, 2'b01, 2'b01, 0, 0, 0, "R6 same address no store");
        step(0, 2'b01, 2'b10, 0, 0, 1, "R10 idle in write mode");
        step(1, 2'b10, 2'b00, 0, 0, 1, "R7 off stores 1 at 0");
        step(1, 2'b01, 2'b01, 0, 0, 0, "R6 read 0");
        // high preset aliases to location 0
        step(1, 2'b01, 2'b00, 0, 0, 0, "R3 preset 6000 R11 alias");
        for (int i = 0; i < 1023; i++)
            step(1, 2'b01, 2'b10, 0, 0, 0, "R2 inc high range R11");
        step(1, 2'b01, 2'b10, 0, 0, 0, "R2 wrap 7777 to 0");
        // write above 1023 and read through alias
        for (int i = 0; i < 1029; i++)
            step(1, 2'b01, 2'b10, 0, 0, 0, "R2 walk to 1029");
        step(1, 2'b10, 2'b01, 0, 0, 0, "R4 wmode on at 1029");
        step(1, 2'b01, 2'b10, 1, 1, 0, "R5 R11 store 1 at 1029");
        step(1, 2'b01, 2'b10, 0, 0, 0, "R5 R11 store 0 at 1030");
        step(1, 2'b10, 2'b00, 0, 0, 1, "R7 R11 store 1 at 1031");
        step(1, 2'b01, 2'b01, 0, 0, 0, "R3 zero");
        for (int i = 0; i < 8; i++)
            step(1, 2'b01, 2'b10, 0, 0, 0, "R11 alias readback");
        // full wrap of 4096
        step(1, 2'b01, 2'b01, 0, 0, 0, "R3 zero before wrap");
        for (int i = 0; i < 4096; i++)
            step(1, 2'b01, 2'b10, 0, 0, 0, "R2 full wrap");
        repeat (3) @(negedge clk);
        cyc_en = 1'b0;
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule